// File: doc/BRIEF.md
# Load-Store Ordering Queue with Speculative Load Issue

This block keeps memory instructions in program order between dispatch and retirement. A slot is allocated for each load or store at the tail of a circular buffer. Later, the pipeline writes the resolved address into the slot, and for a store it also writes the data. Each entry holds its kind, its address, its value, a completion flag and a committed flag.

A load issues as soon as its own address is known, even while older stores still have unknown addresses. When issuing, it looks for older stores with the same address. If the closest of these already holds data, the load takes that data and memory is not accessed. If no older store matches, the load uses a single-cycle memory read port. If a store resolves its address after younger loads to the same location have completed, those loads lose their completion flag. They then issue again in a later cycle and write back the corrected value.

Commit is requested one entry at a time and only for the head entry. A committed entry retires on the next cycle. A retiring store drives its address and data onto the memory write port.

Top module: `ldst_queue`

## Requirements
- R1: After reset the queue is empty (`q_empty`=1, `q_full`=0), `alloc_ready`=1 and `alloc_idx`=0. No writeback, memory read or memory write is signalled.
- R2: Each accepted allocation takes the slot at `alloc_idx`, and `alloc_idx` then advances by one modulo DEPTH. With DEPTH entries live, `q_full`=1 and `alloc_ready`=0, and an allocation request changes neither the slot index nor the occupancy.
- R3: A load with no older store at the same address reads memory. In that cycle `rd_en`=1 with `rd_addr` equal to the load address, and `wb_data` equals `rd_data` with `wb_forwarded`=0.
- R4: A load whose matching older store already holds data writes back that data with `wb_forwarded`=1, and `rd_en` stays 0.
- R5: When several older stores match, the value comes from the one closest to the load in program order.
- R6: If the closest matching older store has no data yet, the load stalls: no writeback and no memory read. It forwards in the first cycle after the data arrives.
- R7: A load whose address is known issues without waiting for older stores whose addresses are still unknown.
- R8: A store that resolves its address clears the completion of every younger completed load at that address. Each such load issues again and writes back the new result.
- R9: A store younger than a load never supplies that load's value.
- R10: `commit_accept` is 1 only when the commit index names the head entry, that entry is complete, and it is not yet committed. The entry retires on the next cycle. A retiring store drives `wr_en`=1 with its address and data, and a retiring load leaves `wr_en` at 0.
- R11: Age is measured from the head pointer, so an entry in a wrapped slot (a lower index) counts as younger than entries nearer the head.
- R12: At most one load issues per cycle. The oldest load with a known address that is not yet complete has priority, and younger loads wait behind it while it stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Request a new slot at the tail |
| alloc_store | input | 1 | Kind of the new slot: 1 store, 0 load |
| alloc_ready | output | 1 | A slot is free |
| alloc_idx | output | IW | Slot index the next allocation receives |
| addr_valid | input | 1 | Address write strobe |
| addr_idx | input | IW | Slot receiving the address |
| addr_value | input | ADDR_W | Resolved address |
| data_valid | input | 1 | Store data write strobe (ignored for loads) |
| data_idx | input | IW | Slot receiving the data |
| data_value | input | DATA_W | Store data |
| commit_valid | input | 1 | Commit request |
| commit_idx | input | IW | Slot named by the commit request |
| commit_accept | output | 1 | Commit request taken this cycle |
| rd_en | output | 1 | Memory read this cycle |
| rd_addr | output | ADDR_W | Memory read address |
| rd_data | input | DATA_W | Memory read data, same cycle |
| wr_en | output | 1 | Retiring store writes memory |
| wr_addr | output | ADDR_W | Memory write address |
| wr_data | output | DATA_W | Memory write data |
| wb_valid | output | 1 | A load completes this cycle |
| wb_idx | output | IW | Slot of the completing load |
| wb_data | output | DATA_W | Value of the completing load |
| wb_forwarded | output | 1 | Value came from an older store |
| q_full | output | 1 | All slots live |
| q_empty | output | 1 | No slot live |

## Verification
The assertions rely on these input rules:
- Address, data and commit indices name live slots.
- Each slot receives its address at most once.
- Data is written only to stores.
- The memory read port answers combinationally.

Under these rules, a forwarded result never coincides with a read, and a memory write always follows an accepted commit by one cycle. The stimulus follows the same rules. It writes each address once, to a slot it has just allocated. It sends data only to stores and commits strictly from the head, and it models memory as a fixed function of the read address.

// File: rtl/ldst_queue_pkg.sv
`timescale 1ns/1ps
package ldst_queue_pkg;

   // Outcome of the load selected for issue in the current cycle.
   typedef enum logic [1:0] {
      EX_IDLE  = 2'd0,
      EX_STALL = 2'd1,
      EX_FWD   = 2'd2,
      EX_MEM   = 2'd3
   } exec_e;

endpackage

// File: rtl/ldst_age_pick.sv
`timescale 1ns/1ps
// Picks one requester by age, measured from the head slot.
// PICK_YOUNGEST=0 returns the oldest requester, 1 the youngest.
module ldst_age_pick #(
   parameter int DEPTH         = 8,
   parameter bit PICK_YOUNGEST = 1'b0,
   localparam int IW           = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0] req,
   input  logic [IW-1:0]    head,
   output logic             hit,
   output logic [IW-1:0]    idx
);

   generate
      if (PICK_YOUNGEST) begin : g_youngest
         always_comb begin
            hit = 1'b0;
            idx = '0;
            for (int k = 0; k < DEPTH; k++) begin
               if (req[head + IW'(k)]) begin
                  hit = 1'b1;
                  idx = head + IW'(k);
               end
            end
         end
      end else begin : g_oldest
         always_comb begin
            hit = 1'b0;
            idx = '0;
            for (int k = DEPTH - 1; k >= 0; k--) begin
               if (req[head + IW'(k)]) begin
                  hit = 1'b1;
                  idx = head + IW'(k);
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/ldst_replay_scan.sv
`timescale 1ns/1ps
// Marks younger loads that a store resolving its address has overtaken.
module ldst_replay_scan #(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 16,
   localparam int IW    = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0]  live,
   input  logic [DEPTH-1:0]  is_store,
   input  logic [DEPTH-1:0]  addr_known,
   input  logic [DEPTH-1:0]  done,
   input  logic [ADDR_W-1:0] addr [DEPTH],
   input  logic [IW-1:0]     head,
   input  logic              st_fire,
   input  logic [IW-1:0]     st_idx,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic              ld_fire,
   input  logic [IW-1:0]     ld_idx,
   output logic [DEPTH-1:0]  replay
);

   logic [IW-1:0] st_age;
   logic [IW-1:0] ent_age;

   always_comb begin
      st_age  = st_idx - head;
      ent_age = '0;
      replay  = '0;
      for (int i = 0; i < DEPTH; i++) begin
         ent_age = IW'(i) - head;
         // A load finishing in this very cycle counts as complete too.
         replay[i] = st_fire && live[i] && !is_store[i] && addr_known[i]
                     && (addr[i] == st_addr) && (ent_age > st_age)
                     && (done[i] || (ld_fire && (ld_idx == IW'(i))));
      end
   end

endmodule

// File: rtl/ldst_queue.sv
`timescale 1ns/1ps
module ldst_queue #(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   localparam int IW    = $clog2(DEPTH),
   localparam int CW    = IW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_valid,
   input  logic              alloc_store,
   output logic              alloc_ready,
   output logic [IW-1:0]     alloc_idx,
   input  logic              addr_valid,
   input  logic [IW-1:0]     addr_idx,
   input  logic [ADDR_W-1:0] addr_value,
   input  logic              data_valid,
   input  logic [IW-1:0]     data_idx,
   input  logic [DATA_W-1:0] data_value,
   input  logic              commit_valid,
   input  logic [IW-1:0]     commit_idx,
   output logic              commit_accept,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_data,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              wb_valid,
   output logic [IW-1:0]     wb_idx,
   output logic [DATA_W-1:0] wb_data,
   output logic              wb_forwarded,
   output logic              q_full,
   output logic              q_empty
);

   initial begin
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0)
         $fatal(1, "ldst_queue: DEPTH must be a power of two, at least 2");
      if (ADDR_W < 1 || DATA_W < 1)
         $fatal(1, "ldst_queue: widths must be positive");
   end

   // Entry state
   logic [DEPTH-1:0]  live_q, store_q, akn_q, dkn_q, done_q, comm_q;
   logic [ADDR_W-1:0] addr_q [DEPTH];
   logic [DATA_W-1:0] data_q [DEPTH];
   logic [IW-1:0]     head_q, tail_q;
   logic [CW-1:0]     count_q;

   // Per-cycle control
   logic                  alloc_fire, retire, ad_fire, dt_fire, st_resolve;
   logic [DEPTH-1:0]      ad_sel, dt_sel;
   logic [DEPTH-1:0]      ld_req, fwd_req, replay;
   logic                  ex_hit, fwd_hit, ex_go;
   logic [IW-1:0]         ex_idx, fwd_idx;
   logic [IW-1:0]         ex_age;
   ldst_queue_pkg::exec_e ex_kind;

   assign q_full      = (count_q == CW'(DEPTH));
   assign q_empty     = (count_q == '0);
   assign alloc_ready = !q_full;
   assign alloc_idx   = tail_q;
   assign alloc_fire  = alloc_valid && !q_full;
   assign retire      = live_q[head_q] && comm_q[head_q];

   assign ad_fire    = addr_valid && live_q[addr_idx];
   assign dt_fire    = data_valid && live_q[data_idx] && store_q[data_idx];
   assign st_resolve = ad_fire && store_q[addr_idx];

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         ad_sel[i] = ad_fire && (addr_idx == IW'(i));
         dt_sel[i] = dt_fire && (data_idx == IW'(i));
         ld_req[i] = live_q[i] && !store_q[i] && akn_q[i] && !done_q[i];
      end
   end

   // Oldest issuable load
   ldst_age_pick #(.DEPTH(DEPTH), .PICK_YOUNGEST(1'b0)) u_ld_pick (
      .req  (ld_req),
      .head (head_q),
      .hit  (ex_hit),
      .idx  (ex_idx)
   );

   // Older stores at the chosen load's address
   assign ex_age = ex_idx - head_q;
   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         fwd_req[i] = live_q[i] && store_q[i] && akn_q[i]
                      && (addr_q[i] == addr_q[ex_idx])
                      && ((IW'(i) - head_q) < ex_age);
      end
   end

   // The closest such store supplies the value
   ldst_age_pick #(.DEPTH(DEPTH), .PICK_YOUNGEST(1'b1)) u_st_pick (
      .req  (fwd_req),
      .head (head_q),
      .hit  (fwd_hit),
      .idx  (fwd_idx)
   );

   always_comb begin
      if (!ex_hit)                        ex_kind = ldst_queue_pkg::EX_IDLE;
      else if (fwd_hit && !dkn_q[fwd_idx]) ex_kind = ldst_queue_pkg::EX_STALL;
      else if (fwd_hit)                   ex_kind = ldst_queue_pkg::EX_FWD;
      else                                ex_kind = ldst_queue_pkg::EX_MEM;
   end

   assign ex_go        = (ex_kind == ldst_queue_pkg::EX_FWD) || (ex_kind == ldst_queue_pkg::EX_MEM);
   assign rd_en        = (ex_kind == ldst_queue_pkg::EX_MEM);
   assign rd_addr      = addr_q[ex_idx];
   assign wb_forwarded = (ex_kind == ldst_queue_pkg::EX_FWD);
   assign wb_data      = wb_forwarded ? data_q[fwd_idx] : rd_data;
   assign wb_idx       = ex_idx;
   assign wb_valid     = ex_go && !replay[ex_idx];

   ldst_replay_scan #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_replay (
      .live       (live_q),
      .is_store   (store_q),
      .addr_known (akn_q),
      .done       (done_q),
      .addr       (addr_q),
      .head       (head_q),
      .st_fire    (st_resolve),
      .st_idx     (addr_idx),
      .st_addr    (addr_value),
      .ld_fire    (ex_go),
      .ld_idx     (ex_idx),
      .replay     (replay)
   );

   assign commit_accept = commit_valid && (commit_idx == head_q) && live_q[head_q]
                          && done_q[head_q] && !comm_q[head_q];

   assign wr_en   = retire && store_q[head_q];
   assign wr_addr = addr_q[head_q];
   assign wr_data = data_q[head_q];

   // Flags and pointers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q  <= '0;
         store_q <= '0;
         akn_q   <= '0;
         dkn_q   <= '0;
         done_q  <= '0;
         comm_q  <= '0;
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (alloc_fire && (tail_q == IW'(i))) begin
               live_q[i]  <= 1'b1;
               store_q[i] <= alloc_store;
               akn_q[i]   <= 1'b0;
               dkn_q[i]   <= 1'b0;
               done_q[i]  <= 1'b0;
               comm_q[i]  <= 1'b0;
            end else begin
               if (retire && (head_q == IW'(i))) live_q[i] <= 1'b0;
               if (ad_sel[i]) akn_q[i] <= 1'b1;
               if (dt_sel[i]) dkn_q[i] <= 1'b1;
               if (store_q[i] && live_q[i]
                   && (akn_q[i] || ad_sel[i]) && (dkn_q[i] || dt_sel[i]))
                  done_q[i] <= 1'b1;
               if (wb_valid && (ex_idx == IW'(i))) done_q[i] <= 1'b1;
               if (replay[i]) done_q[i] <= 1'b0;
               if (commit_accept && (head_q == IW'(i))) comm_q[i] <= 1'b1;
            end
         end
         if (alloc_fire) tail_q <= tail_q + 1'b1;
         if (retire)     head_q <= head_q + 1'b1;
         case ({alloc_fire, retire})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   // Payload storage, no reset needed
   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (ad_sel[i]) addr_q[i] <= addr_value;
         if (dt_sel[i]) data_q[i] <= data_value;
         else if (wb_valid && (ex_idx == IW'(i))) data_q[i] <= wb_data;
      end
   end

endmodule

// File: rtl/ldst_queue_chk.sv
`timescale 1ns/1ps
module ldst_queue_chk (
   input logic clk,
   input logic rst_n,
   input logic alloc_ready,
   input logic q_full,
   input logic q_empty,
   input logic rd_en,
   input logic wr_en,
   input logic wb_valid,
   input logic wb_forwarded,
   input logic commit_accept
);

   p_full_blocks_alloc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      q_full |-> !alloc_ready);

   p_full_empty_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(q_full && q_empty));

   p_empty_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      q_empty |-> (!wb_valid && !wr_en && !rd_en));

   p_mem_result_uses_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !wb_forwarded) |-> rd_en);

   p_fwd_skips_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && wb_forwarded) |-> !rd_en);

   p_store_retire_after_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(commit_accept));

endmodule

bind ldst_queue ldst_queue_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .alloc_ready   (alloc_ready),
   .q_full        (q_full),
   .q_empty       (q_empty),
   .rd_en         (rd_en),
   .wr_en         (wr_en),
   .wb_valid      (wb_valid),
   .wb_forwarded  (wb_forwarded),
   .commit_accept (commit_accept)
);

// File: tb/ldst_queue_bench.sv
`timescale 1ns/1ps
module ldst_queue_bench;

   localparam int DEPTH  = 8;
   localparam int ADDR_W = 16;
   localparam int DATA_W = 32;
   localparam int IW     = $clog2(DEPTH);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              alloc_valid = 1'b0, alloc_store = 1'b0;
   logic              alloc_ready;
   logic [IW-1:0]     alloc_idx;
   logic              addr_valid = 1'b0;
   logic [IW-1:0]     addr_idx = '0;
   logic [ADDR_W-1:0] addr_value = '0;
   logic              data_valid = 1'b0;
   logic [IW-1:0]     data_idx = '0;
   logic [DATA_W-1:0] data_value = '0;
   logic              commit_valid = 1'b0;
   logic [IW-1:0]     commit_idx = '0;
   logic              commit_accept;
   logic              rd_en;
   logic [ADDR_W-1:0] rd_addr;
   logic [DATA_W-1:0] rd_data;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic              wb_valid;
   logic [IW-1:0]     wb_idx;
   logic [DATA_W-1:0] wb_data;
   logic              wb_forwarded;
   logic              q_full, q_empty;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   // Memory model: value is a fixed function of the address
   function automatic logic [DATA_W-1:0] mem_of(input logic [ADDR_W-1:0] a);
      return {~a, a};
   endfunction
   assign rd_data = mem_of(rd_addr);

   ldst_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ldst_queue (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_store(alloc_store),
      .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
      .addr_valid(addr_valid), .addr_idx(addr_idx), .addr_value(addr_value),
      .data_valid(data_valid), .data_idx(data_idx), .data_value(data_value),
      .commit_valid(commit_valid), .commit_idx(commit_idx), .commit_accept(commit_accept),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data), .wb_forwarded(wb_forwarded),
      .q_full(q_full), .q_empty(q_empty)
   );

   task automatic chk_eq(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Scoreboard of expected load writebacks
   typedef struct {
      int                idx;
      logic [DATA_W-1:0] data;
      bit                fwd;
      string             req;
   } wb_exp_t;
   wb_exp_t exp_q[$];
   wb_exp_t cur;

   task automatic expect_wb(input int idx, input logic [DATA_W-1:0] d,
                            input bit fwd, input string req);
      wb_exp_t e;
      e.idx = idx; e.data = d; e.fwd = fwd; e.req = req;
      exp_q.push_back(e);
   endtask

   always @(negedge clk) begin
      if (rst_n && wb_valid) begin
         if (exp_q.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R12 unexpected writeback: actual idx %0d data %0h expected none",
                     wb_idx, wb_data);
         end else begin
            cur = exp_q.pop_front();
            chk_eq(cur.req, "writeback index", 64'(wb_idx), 64'(cur.idx));
            chk_eq(cur.req, "writeback data", 64'(wb_data), 64'(cur.data));
            chk_eq(cur.req, "writeback forwarded", 64'(wb_forwarded), 64'(cur.fwd));
            if (!cur.fwd) chk_eq("R3", "read issued for memory load", 64'(rd_en), 64'd1);
            else          chk_eq("R4", "no read on forward", 64'(rd_en), 64'd0);
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic do_alloc(input bit st, input int exp_idx);
      alloc_valid = 1'b1;
      alloc_store = st;
      @(negedge clk);
      chk_eq("R2", "alloc index", 64'(alloc_idx), 64'(exp_idx));
      chk_eq("R2", "alloc ready", 64'(alloc_ready), 64'd1);
      tick();
      alloc_valid = 1'b0;
   endtask

   task automatic set_addr(input int idx, input logic [ADDR_W-1:0] a);
      addr_valid = 1'b1; addr_idx = IW'(idx); addr_value = a;
      tick();
      addr_valid = 1'b0;
   endtask

   task automatic set_store(input int idx, input logic [ADDR_W-1:0] a,
                            input logic [DATA_W-1:0] d);
      addr_valid = 1'b1; addr_idx = IW'(idx); addr_value = a;
      data_valid = 1'b1; data_idx = IW'(idx); data_value = d;
      tick();
      addr_valid = 1'b0; data_valid = 1'b0;
   endtask

   task automatic do_commit(input int idx, input bit st,
                            input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      commit_valid = 1'b1; commit_idx = IW'(idx);
      @(negedge clk);
      chk_eq("R10", "commit accepted at head", 64'(commit_accept), 64'd1);
      tick();
      commit_valid = 1'b0;
      @(negedge clk);
      chk_eq("R10", "write enable on retire", 64'(wr_en), 64'(st));
      if (st) begin
         chk_eq("R10", "retire write address", 64'(wr_addr), 64'(a));
         chk_eq("R10", "retire write data", 64'(wr_data), 64'(d));
      end
      tick();
   endtask

   task automatic commit_refused(input int idx, input string why);
      commit_valid = 1'b1; commit_idx = IW'(idx);
      @(negedge clk);
      chk_eq("R10", why, 64'(commit_accept), 64'd0);
      tick();
      commit_valid = 1'b0;
   endtask

   bit finished = 1'b0;

   initial begin
      #(4 * 150000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      @(negedge clk);
      chk_eq("R1", "empty after reset", 64'(q_empty), 64'd1);
      chk_eq("R1", "not full after reset", 64'(q_full), 64'd0);
      chk_eq("R1", "alloc ready after reset", 64'(alloc_ready), 64'd1);
      chk_eq("R1", "alloc index after reset", 64'(alloc_idx), 64'd0);
      chk_eq("R1", "no wb/rd/wr after reset", {61'd0, wb_valid, rd_en, wr_en}, 64'd0);
      tick();

      // Phase A: forwarding choice (R4, R5, R9) and memory read (R3)
      do_alloc(1'b1, 0);
      do_alloc(1'b1, 1);
      do_alloc(1'b0, 2);
      do_alloc(1'b1, 3);
      do_alloc(1'b0, 4);
      set_store(0, 16'h0010, 32'h0000_0111);
      set_store(1, 16'h0010, 32'h0000_0222);
      set_store(3, 16'h0010, 32'h0000_0333);
      expect_wb(2, 32'h0000_0222, 1'b1, "R5_R9");
      set_addr(2, 16'h0010);
      expect_wb(4, mem_of(16'h0020), 1'b0, "R3");
      set_addr(4, 16'h0020);
      tick();
      commit_refused(1, "commit to non-head refused");
      do_commit(0, 1'b1, 16'h0010, 32'h0000_0111);
      do_commit(1, 1'b1, 16'h0010, 32'h0000_0222);
      do_commit(2, 1'b0, '0, '0);
      do_commit(3, 1'b1, 16'h0010, 32'h0000_0333);
      do_commit(4, 1'b0, '0, '0);
      @(negedge clk);
      chk_eq("R2", "empty after phase A", 64'(q_empty), 64'd1);
      tick();

      // Phase B: issue ahead (R7), late store (R8), stall (R6), order (R12), wrap (R11)
      do_alloc(1'b1, 5);
      do_alloc(1'b0, 6);
      do_alloc(1'b1, 7);
      do_alloc(1'b0, 0);
      do_alloc(1'b0, 1);
      expect_wb(6, mem_of(16'h0030), 1'b0, "R7");
      set_addr(6, 16'h0030);
      tick();
      set_addr(5, 16'h0030);
      addr_valid = 1'b1; addr_idx = IW'(1); addr_value = 16'h0060;
      @(negedge clk);
      chk_eq("R6", "stalled load: no writeback", 64'(wb_valid), 64'd0);
      chk_eq("R6", "stalled load: no read", 64'(rd_en), 64'd0);
      tick();
      addr_valid = 1'b0;
      data_valid = 1'b1; data_idx = IW'(5); data_value = 32'h0000_0555;
      expect_wb(6, 32'h0000_0555, 1'b1, "R8");
      expect_wb(1, mem_of(16'h0060), 1'b0, "R12");
      @(negedge clk);
      chk_eq("R12", "younger load waits behind stall", 64'(wb_valid), 64'd0);
      chk_eq("R6", "still no read while stalled", 64'(rd_en), 64'd0);
      tick();
      data_valid = 1'b0;
      tick();
      tick();
      set_store(7, 16'h0040, 32'h0000_0777);
      expect_wb(0, 32'h0000_0777, 1'b1, "R11");
      set_addr(0, 16'h0040);
      tick();
      do_commit(5, 1'b1, 16'h0030, 32'h0000_0555);
      do_commit(6, 1'b0, '0, '0);
      do_commit(7, 1'b1, 16'h0040, 32'h0000_0777);
      do_commit(0, 1'b0, '0, '0);
      do_commit(1, 1'b0, '0, '0);

      // Phase C: full queue (R2) and incomplete head (R10)
      for (int k = 0; k < DEPTH; k++) do_alloc(1'b0, (2 + k) % DEPTH);
      @(negedge clk);
      chk_eq("R2", "full flag", 64'(q_full), 64'd1);
      chk_eq("R2", "alloc ready low when full", 64'(alloc_ready), 64'd0);
      alloc_valid = 1'b1; alloc_store = 1'b1;
      tick();
      alloc_valid = 1'b0;
      @(negedge clk);
      chk_eq("R2", "refused alloc keeps index", 64'(alloc_idx), 64'd2);
      chk_eq("R2", "refused alloc keeps full", 64'(q_full), 64'd1);
      tick();
      commit_refused(2, "commit of incomplete head refused");
      for (int k = 0; k < DEPTH; k++) begin
         expect_wb((2 + k) % DEPTH, mem_of(ADDR_W'(16'h0100 + k)), 1'b0, "R3");
         set_addr((2 + k) % DEPTH, ADDR_W'(16'h0100 + k));
      end
      tick();
      for (int k = 0; k < DEPTH; k++) do_commit((2 + k) % DEPTH, 1'b0, '0, '0);
      @(negedge clk);
      chk_eq("R2", "empty at end", 64'(q_empty), 64'd1);
      chk_eq("R12", "all expected writebacks seen", 64'(exp_q.size()), 64'd0);

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule